// File: doc/BRIEF.md
# I2C Master Receive Engine with Host Handshake

This block is the receive half of an I2C master. Once the bus is owned and the slave has been addressed, a host processor runs the transfer through a small register port. The engine clocks bytes in from the slave most significant bit first and drives the acknowledge bit itself. At the end of every byte it raises an interrupt flag. Both bus lines are open-drain and are driven as pull-low enables, and SDA is read back through a synchroniser.

With the handshake option set, the host paces the bus. SCL stays low after each byte until the host reads the data register, and that read releases the clock for the next byte. The host decides to NACK by setting a control bit before the last byte arrives. After the NACKed byte, SCL stays low until the host asks for a stop condition. The engine then generates the stop, and the host collects the final byte afterwards without starting another one.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset both pull-low enables and the interrupt are 0, the status register (addr 2) reads 0, and the control register (addr 1) reads 0x01, which means transmit direction.
- R2: The control register has these bits: bit0 selects transmit (1) or receive (0), bit1 selects NACK, bit2 enables handshake, bit3 claims the bus and bit4 is the condition bit. Writing control with bit3=1 makes the bus busy and holds SCL low. With receive selected, a read of the data register (addr 0) starts the first byte. That read returns a value with no meaning. No SCL edge appears before that read.
- R3: Each byte uses 9 SCL clocks. SDA is sampled on every SCL rise and the bits arrive MSB first. With the NACK bit at 0, the master pulls SDA low for the whole 9th clock.
- R4: With handshake enabled, SCL is held low after the 9th clock until the data register is read. That read returns the byte and releases SCL for the next byte.
- R5: At the end of each byte, status bit0 (interrupt, also on `irq`) and status bit1 (receive-full) are set. Writing status with bit0=0 clears the interrupt. A data-register read clears receive-full.
- R6: If the NACK bit is 1 before a byte's 9th clock begins, SDA is released (NACK) on that clock. SCL then stays low, and a data-register read does not release it.
- R7: Writing control with bit3=0 and bit4=0 while busy requests a stop. While SCL is low, SDA is pulled low. SCL is then released, and SDA is released one half-period later. Status bit2 (busy) then clears and both lines stay released.
- R8: A data-register read made after the stop request returns the last byte and produces no further SCL edge.
- R9: A data-register read while a byte is being shifted in returns the previous byte. The read leaves the byte in flight intact.
- R10: Each SCL high half lasts `clk_div` system clocks. Within a byte, rising edges are 2×`clk_div` clocks apart.
- R11: With handshake disabled, an ACKed byte is followed at once by the next byte, with no host read needed.
- R12: SDA never falls while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCL half-period in system clocks |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Byte-complete interrupt flag |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The assertions assume the slave changes SDA only while SCL is low. They also assume `clk_div` is larger than the synchroniser depth, so that a bit the slave set at the falling edge has settled before the next rise samples it. They further assume the host issues no stop while a byte is in flight. The bench's slave model updates its data only on SCL falling edges and releases SDA after it sees a NACK. The bench holds `clk_div` at 5 and requests the stop only after the final byte's interrupt. Byte values, lengths and handshake mode are drawn at random, alongside directed all-zero and all-one bytes.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_HOLD,
      ST_STOP_LO,
      ST_STOP_HI
   } rx_state_e;

   localparam logic [1:0] A_DATA = 2'd0;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;

   localparam int C_XMIT = 0;
   localparam int C_NACK = 1;
   localparam int C_HOLD = 2;
   localparam int C_OWN  = 3;
   localparam int C_COND = 4;

   localparam int S_IRQ  = 0;
   localparam int S_FULL = 1;
   localparam int S_BUSY = 2;

   localparam int BYTE_W   = 8;
   localparam int BITS_PER = BYTE_W + 1;
endpackage

// File: rtl/i2c_rx_tick.sv
module i2c_rx_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   assign lim  = (div == '0) ? DIV_W'(1) : div;
   assign tick = run && (cnt >= lim - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + DIV_W'(1);
   end

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < lim));
endmodule

// File: rtl/i2c_rx_shift.sv
module i2c_rx_shift
   import i2c_rx_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic              sda_s,
   output logic              scl_hi,
   output logic [CNT_W-1:0]  bitcnt,
   output logic [BYTE_W-1:0] shreg,
   output logic              byte_done
);
   localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_W);

   assign byte_done = active && tick && scl_hi && (bitcnt == ACK_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_hi <= 1'b0;
         bitcnt <= '0;
         shreg  <= '0;
      end else if (active && tick) begin
         if (!scl_hi) begin
            scl_hi <= 1'b1;
            if (bitcnt < ACK_IDX) shreg <= {shreg[BYTE_W-2:0], sda_s};
         end else begin
            scl_hi <= 1'b0;
            bitcnt <= (bitcnt == ACK_IDX) ? '0 : bitcnt + CNT_W'(1);
         end
      end
   end

   // R3
   bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= ACK_IDX);
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
   import i2c_rx_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] clk_div,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [1:0]       addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata,
   output logic             irq,
   output logic             scl_oe,
   output logic             sda_oe,
   input  logic             sda_in
);
   localparam int CNT_W = $clog2(BITS_PER + 1);
   localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(BYTE_W);

   generate
      if (DIV_W < 2) begin : g_bad_div
         $error("DIV_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   rx_state_e         state;
   logic [2:0]        ctrl_q;
   logic              busy_q, stop_req, irq_q, rx_full_q;
   logic              nack_cur, sent_nack;
   logic [BYTE_W-1:0] data_q;
   logic              sda_s, tick, run;
   logic              scl_hi, byte_done;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              data_rd, ctrl_wr, stat_wr;
   logic              unused_bits;

   assign unused_bits = ^{wdata[7:5], wdata[2:1]};
   assign data_rd = rd_en && (addr == A_DATA);
   assign ctrl_wr = wr_en && (addr == A_CTRL);
   assign stat_wr = wr_en && (addr == A_STAT);

   // SDA input synchroniser, depth chosen by parameter
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_in;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic s1;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s1 <= 1'b1;
            else        s1 <= sda_in;
         end
         assign sda_s = s1;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sq;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq <= '1;
            else        sq <= {sq[SYNC_STAGES-2:0], sda_in};
         end
         assign sda_s = sq[SYNC_STAGES-1];
      end
   endgenerate

   assign run = (state == ST_SHIFT) || (state == ST_STOP_LO) || (state == ST_STOP_HI);

   i2c_rx_tick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (clk_div),
      .tick  (tick)
   );

   i2c_rx_shift #(.CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (state == ST_SHIFT),
      .tick      (tick),
      .sda_s     (sda_s),
      .scl_hi    (scl_hi),
      .bitcnt    (bitcnt),
      .shreg     (shreg),
      .byte_done (byte_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         ctrl_q    <= 3'b001;
         busy_q    <= 1'b0;
         stop_req  <= 1'b0;
         irq_q     <= 1'b0;
         rx_full_q <= 1'b0;
         nack_cur  <= 1'b0;
         sent_nack <= 1'b0;
         data_q    <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl_q <= wdata[2:0];
            if (wdata[C_OWN])                 busy_q   <= 1'b1;
            else if (!wdata[C_COND] && busy_q) stop_req <= 1'b1;
         end
         if (stat_wr && !wdata[S_IRQ]) irq_q <= 1'b0;
         if (data_rd) rx_full_q <= 1'b0;
         if (state == ST_SHIFT && bitcnt < ACK_IDX) nack_cur <= ctrl_q[C_NACK];
         if (byte_done) begin
            data_q    <= shreg;
            irq_q     <= 1'b1;
            rx_full_q <= 1'b1;
            sent_nack <= nack_cur;
         end
         unique case (state)
            ST_IDLE: begin
               if (stop_req) state <= ST_STOP_LO;
               else if (busy_q && !ctrl_q[C_XMIT] && data_rd) begin
                  state     <= ST_SHIFT;
                  sent_nack <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (byte_done && (nack_cur || ctrl_q[C_HOLD] || stop_req))
                  state <= ST_HOLD;
            end
            ST_HOLD: begin
               if (stop_req)                    state <= ST_STOP_LO;
               else if (data_rd && !sent_nack)  state <= ST_SHIFT;
            end
            ST_STOP_LO: if (tick) state <= ST_STOP_HI;
            ST_STOP_HI: begin
               if (tick) begin
                  state    <= ST_IDLE;
                  busy_q   <= 1'b0;
                  stop_req <= 1'b0;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      scl_oe = 1'b0;
      sda_oe = 1'b0;
      unique case (state)
         ST_IDLE:    scl_oe = busy_q;
         ST_SHIFT: begin
            scl_oe = !scl_hi;
            sda_oe = (bitcnt == ACK_IDX) && !nack_cur;
         end
         ST_HOLD:    scl_oe = 1'b1;
         ST_STOP_LO: begin scl_oe = 1'b1; sda_oe = 1'b1; end
         ST_STOP_HI: sda_oe = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      unique case (addr)
         A_DATA:  rdata = data_q;
         A_CTRL:  rdata = {4'b0, busy_q, ctrl_q};
         A_STAT:  rdata = {5'b0, busy_q, rx_full_q, irq_q};
         default: rdata = '0;
      endcase
   end

   assign irq = irq_q;

   // R4
   hold_keeps_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && !data_rd && !stop_req) |=> scl_oe);

   // R12
   sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_oe && !$past(scl_oe) && $past(state) != ST_STOP_HI) |-> $stable(sda_oe));

   // R6
   nack_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD && sent_nack) |=> (state != ST_SHIFT));

   // R5
   done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done |=> (irq_q && rx_full_q));

   // R7
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/test_i2c_rx_master.sv
module test_i2c_rx_master;
   localparam int DIV = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] clk_div = 8'(DIV);
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       irq, scl_oe, sda_oe;
   logic       scl_line, sda_line, slave_oe;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   // slave model state
   logic [7:0] sl_bytes [0:7];
   logic       ack_seen [0:7];
   logic       sl_arm = 1'b0, sl_done = 1'b0;
   logic [3:0] sl_bc = 4'd0;
   logic [2:0] sl_idx = 3'd0;

   // line monitors
   int  scl_rises = 0, stop_cnt = 0, start_cnt = 0;
   int  hi_bad = 0, per_bad = 0, hi_cnt = 0, since_rise = 0;
   bit  in_xfer = 0;
   logic scl_prev = 1'b1;

   always #10 clk = ~clk;

   assign scl_line = ~scl_oe;
   assign sda_line = ~(sda_oe | slave_oe);
   assign slave_oe = sl_arm && !sl_done && (sl_bc < 4'd8) && !sl_bytes[sl_idx][3'(4'd7 - sl_bc)];

   i2c_rx_master i_i2c_rx_master (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
   );

   always @(posedge scl_line)
      if (sl_arm && !sl_done && sl_bc == 4'd8) ack_seen[sl_idx] = sda_line;

   always @(negedge scl_line)
      if (sl_arm && !sl_done) begin
         if (sl_bc == 4'd8) begin
            sl_bc = 4'd0;
            if (ack_seen[sl_idx]) sl_done = 1'b1;
            sl_idx = sl_idx + 3'd1;
         end else sl_bc = sl_bc + 4'd1;
      end

   always @(posedge sda_line) if (scl_line) stop_cnt++;
   always @(negedge sda_line) if (scl_line && rst_n) start_cnt++;

   always @(negedge clk) begin
      if (scl_line && !scl_prev) begin
         scl_rises++;
         if (in_xfer && since_rise < 2*DIV) per_bad++;
         since_rise = 1;
         hi_cnt = 1;
      end else begin
         since_rise++;
         if (scl_line) hi_cnt++;
      end
      if (!scl_line && scl_prev && in_xfer && hi_cnt != DIV) hi_bad++;
      scl_prev = scl_line;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic wait_irq(input string req);
      int t = 0;
      while (!irq && t < 3000) begin @(negedge clk); t++; end
      chk(irq === 1'b1, req, int'(irq), 1);
   endtask

   function automatic logic [7:0] ctrl_val(input bit own, input bit cond, input bit hold, input bit nack);
      return {3'b000, cond, own, hold, nack, 1'b0};
   endfunction

   task automatic run_xfer(input int n, input bit hold);
      logic [7:0] v;
      int r0, s0, t;
      for (int k = 0; k < 8; k++) ack_seen[k] = 1'b0;
      wr(2'd1, ctrl_val(1, 1, hold, n == 1));
      sl_bc = 4'd0; sl_idx = 3'd0; sl_done = 1'b0; sl_arm = 1'b1;
      r0 = scl_rises;
      repeat (12) @(negedge clk);
      chk(scl_line == 1'b0 && scl_rises == r0, "R2 no clock before dummy read", scl_rises - r0, 0);
      in_xfer = 1;
      rd(2'd0, v);                                   // dummy read, R2
      for (int i = 0; i < n; i++) begin
         wait_irq("R5 irq at byte end");
         chk(ack_seen[i] == (i == n-1), (i == n-1) ? "R6 NACK on last byte" : "R3 ACK driven",
             int'(ack_seen[i]), int'(i == n-1));
         if (!hold && i < n-1) begin
            r0 = scl_rises;
            repeat (12) @(negedge clk);
            chk(scl_rises > r0, "R11 next byte without read", scl_rises - r0, 1);
         end
         if (hold || i == n-1) begin
            r0 = scl_rises;
            repeat (12) @(negedge clk);
            chk(scl_line == 1'b0 && scl_rises == r0, hold ? "R4 SCL held" : "R6 SCL held", scl_rises - r0, 0);
         end
         rd(2'd2, v);
         chk(v[1:0] == 2'b11, "R5 status flags", int'(v[1:0]), 3);
         wr(2'd2, 8'h00);
         chk(irq == 1'b0, "R5 irq clear", int'(irq), 0);
         if (i < n-1) begin
            if (i == n-2) wr(2'd1, ctrl_val(1, 1, hold, 1));
            rd(2'd0, v);
            chk(v == sl_bytes[i], "R2 byte MSB first", int'(v), int'(sl_bytes[i]));
            rd(2'd2, v);
            chk(v[1] == 1'b0, "R5 full cleared", int'(v[1]), 0);
            if (i == 0 && hold) begin
               repeat (30) @(negedge clk);
               rd(2'd0, v);
               chk(v == sl_bytes[0], "R9 mid-byte read", int'(v), int'(sl_bytes[0]));
            end
         end else begin
            s0 = stop_cnt;
            in_xfer = 0;
            wr(2'd1, ctrl_val(0, 0, hold, 1));
            if (n % 2 == 1) begin
               rd(2'd0, v);
               chk(v == sl_bytes[i], "R8 last byte during stop", int'(v), int'(sl_bytes[i]));
            end
            t = 0;
            v = 8'h04;
            while (v[2] && t < 200) begin rd(2'd2, v); t++; end
            chk(v[2] == 1'b0, "R7 busy clears", int'(v[2]), 0);
            chk(stop_cnt == s0 + 1, "R7 stop seen", stop_cnt - s0, 1);
            chk(scl_line && sda_line, "R7 lines released", {30'd0, scl_line, sda_line}, 3);
            r0 = scl_rises;
            rd(2'd0, v);
            chk(v == sl_bytes[i], "R8 last byte after stop", int'(v), int'(sl_bytes[i]));
            repeat (40) @(negedge clk);
            chk(scl_rises == r0 && scl_line, "R8 no new byte", scl_rises - r0, 0);
         end
      end
      sl_arm = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      int seed;
      seed = int'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(scl_oe == 0 && sda_oe == 0 && irq == 0, "R1 outputs idle", {29'd0, scl_oe, sda_oe, irq}, 0);
      rd(2'd2, v); chk(v == 8'h00, "R1 status", int'(v), 0);
      rd(2'd1, v); chk(v == 8'h01, "R1 control", int'(v), 1);

      sl_bytes[0] = 8'h00; sl_bytes[1] = 8'hFF; sl_bytes[2] = 8'hA5;
      run_xfer(3, 1);
      sl_bytes[0] = 8'h5A; sl_bytes[1] = 8'hC3;
      run_xfer(2, 0);
      sl_bytes[0] = 8'h81;
      run_xfer(1, 1);
      for (int j = 0; j < 5; j++) begin
         int n;
         bit h;
         n = 1 + int'($urandom_range(3));
         h = bit'($urandom % 2);
         for (int k = 0; k < 8; k++) sl_bytes[k] = 8'($urandom);
         run_xfer(n, h);
      end

      chk(hi_bad == 0, "R10 high half", hi_bad, 0);
      chk(per_bad == 0, "R10 bit period", per_bad, 0);
      chk(start_cnt == 0, "R12 no SDA fall with SCL high", start_cnt, 0);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule